// File: doc/BRIEF.md
# Montgomery Reduction Unit

This unit reduces a 64-bit product by Montgomery's method, as lattice-based cryptography needs it for modular multiplication in number-theoretic transforms. Each issued operation takes three inputs. The first is the value to reduce. The second is the modulus. The third is a negative-inverse constant, which the unit holds in one of two internal registers loaded ahead of time through a small configuration port.

An opcode selects one of three variants:
- a 16-bit-radix form that subtracts,
- a 16-bit-radix form that adds,
- a 32-bit-radix form that subtracts.

The result is registered and appears one clock after issue, widened to 64 bits. The unit does not perform the final correction into [0, q). The multiplication that produces its input and the surrounding transform sequencing are also outside it.

Top module: `montReduce`

## Requirements
- R1: With opcode 0, t is the low 16 bits of inA[15:0] times the narrow constant, read as a signed 16-bit value. The result is (inA − t·inQ) taken modulo 2^64, then shifted right arithmetically by 16.
- R2: With opcode 1, t is the same low 16 bits read as unsigned. The result is (inA + t·inQ) taken modulo 2^64, then shifted right logically by 16.
- R3: With opcode 2, t is the low 32 bits of inA[31:0] times the wide constant, read as a signed 32-bit value. The result is (inA − t·inQ) taken modulo 2^64, then shifted right arithmetically by 32.
- R4: Opcode 3 is reserved. An issued reserved operation produces a result of zero.
- R5: outValid is high in exactly the cycle after a cycle with inValid high. outData in that cycle holds the result of that issue.
- R6: When inValid is low, outData keeps its previous value whatever inA, inQ and inOp carry.
- R7: A configuration write (cfgWrEn high) updates a constant on the next clock edge. cfgSel 0 loads cfgData[15:0] into the narrow constant, ignoring cfgData[31:16]. cfgSel 1 loads all of cfgData[31:0] into the wide constant. A reduction issued in the same cycle as the write still uses the old value.
- R8: Reset (rstN low) clears outData, outValid and both constants to zero.
- R9: Results of opcodes 0 and 2 are sign-extended: bits 63:47 are all equal for opcode 0, and bits 63:31 are all equal for opcode 2. Results of opcode 1 have bits 63:48 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| cfgWrEn | input | 1 | Constant write strobe |
| cfgSel | input | 1 | 0 selects the narrow constant, 1 the wide constant |
| cfgData | input | 32 | Constant value to write |
| inValid | input | 1 | Issues a reduction this cycle |
| inOp | input | 2 | 0 narrow subtract, 1 narrow add, 2 wide subtract, 3 reserved |
| inA | input | 64 | Value to reduce |
| inQ | input | 64 | Modulus |
| outValid | output | 1 | Result present this cycle |
| outData | output | 64 | Reduced value, widened to 64 bits |

## Verification
Every reduction result and its outValid are due exactly one clock edge after the cycle in which inValid was sampled high. A configuration write shows up in a reduction issued in the cycle after the write. The bench drives all inputs just after a falling edge and reads outData and outValid at the next falling edge, which lies half a period after the single capturing rising edge. The hold and same-cycle-write cases are checked at that same falling edge, before any further stimulus can move the register.

// File: rtl/montPkg.sv
package montPkg;

  typedef enum logic [1:0] {
    OP_SUB_NARROW = 2'd0,
    OP_ADD_NARROW = 2'd1,
    OP_SUB_WIDE   = 2'd2,
    OP_RESERVED   = 2'd3
  } montOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // register a new result
    logic useAdd;    // add form, unsigned t, logical shift
    logic wide;      // 32-bit radix
    logic zeroOut;   // reserved opcode
    logic ldNarrow;  // load narrow constant
    logic ldWide;    // load wide constant
  } montStrobe_t;

endpackage

// File: rtl/montCtrl.sv
module montCtrl
  import montPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  inOp,
  input  logic        cfgWrEn,
  input  logic        cfgSel,
  output montStrobe_t strobe,
  output logic        outValid
);

  montOp_e opCode;
  assign opCode = montOp_e'(inOp);

  always_comb begin
    strobe          = '0;
    strobe.capture  = inValid;
    strobe.ldNarrow = cfgWrEn & ~cfgSel;
    strobe.ldWide   = cfgWrEn & cfgSel;
    case (opCode)
      OP_SUB_NARROW: begin
        strobe.useAdd = 1'b0;
        strobe.wide   = 1'b0;
      end
      OP_ADD_NARROW: strobe.useAdd = 1'b1;
      OP_SUB_WIDE:   strobe.wide = 1'b1;
      default:       strobe.zeroOut = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R5: valid appears one cycle after issue and only then
  p_valid_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/montDatapath.sv
module montDatapath
  import montPkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_R = 16,
  parameter int WIDE_R   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  montStrobe_t       strobe,
  input  logic [WIDE_R-1:0] cfgData,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inQ,
  output logic [DATA_W-1:0] outData
);

  localparam int N_EXT = DATA_W - NARROW_R;
  localparam int W_EXT = DATA_W - WIDE_R;

  logic [NARROW_R-1:0] narrowInv;
  logic [WIDE_R-1:0]   wideInv;
  logic [NARROW_R-1:0] tNarrow;
  logic [WIDE_R-1:0]   tWide;
  logic [DATA_W-1:0]   tExt;
  logic [DATA_W-1:0]   tTimesQ;
  logic [DATA_W-1:0]   accum;
  logic [DATA_W-1:0]   shifted;
  logic [DATA_W-1:0]   result;

  // constant registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      narrowInv <= '0;
      wideInv   <= '0;
    end else begin
      if (strobe.ldNarrow) narrowInv <= cfgData[NARROW_R-1:0];
      if (strobe.ldWide)   wideInv   <= cfgData;
    end
  end

  // masked quotient estimates
  assign tNarrow = NARROW_R'(inA[NARROW_R-1:0] * narrowInv);
  assign tWide   = WIDE_R'(inA[WIDE_R-1:0] * wideInv);

  always_comb begin
    if (strobe.wide)
      tExt = {{W_EXT{tWide[WIDE_R-1]}}, tWide};
    else if (strobe.useAdd)
      tExt = {{N_EXT{1'b0}}, tNarrow};
    else
      tExt = {{N_EXT{tNarrow[NARROW_R-1]}}, tNarrow};
  end

  assign tTimesQ = DATA_W'(tExt * inQ);
  assign accum   = strobe.useAdd ? (inA + tTimesQ) : (inA - tTimesQ);

  always_comb begin
    if (strobe.wide)
      shifted = $unsigned($signed(accum) >>> WIDE_R);
    else if (strobe.useAdd)
      shifted = accum >> NARROW_R;
    else
      shifted = $unsigned($signed(accum) >>> NARROW_R);
  end

  assign result = strobe.zeroOut ? '0 : shifted;

  always_ff @(posedge clk) begin
    if (!rstN)               outData <= '0;
    else if (strobe.capture) outData <= result;
  end

  // R6: no issue, no change
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(outData));
  // R4: reserved opcode yields zero
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.zeroOut) |=> (outData == '0));
  // R9: add form leaves the top bits clear
  p_add_top_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.useAdd && !strobe.zeroOut)
      |=> (outData[DATA_W-1:DATA_W-NARROW_R] == '0));
  // R9: narrow subtract result is sign-extended
  p_narrow_sext_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.useAdd && !strobe.wide && !strobe.zeroOut)
      |=> ((&outData[DATA_W-1:N_EXT-1]) || !(|outData[DATA_W-1:N_EXT-1])));
  // R9: wide subtract result is sign-extended
  p_wide_sext_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.wide && !strobe.zeroOut)
      |=> ((&outData[DATA_W-1:W_EXT-1]) || !(|outData[DATA_W-1:W_EXT-1])));

endmodule

// File: rtl/montReduce.sv
module montReduce
  import montPkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_R = 16,
  parameter int WIDE_R   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [WIDE_R-1:0] cfgData,
  input  logic              inValid,
  input  logic [1:0]        inOp,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inQ,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  montStrobe_t strobe;

  montCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inOp     (inOp),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  montDatapath #(
    .DATA_W   (DATA_W),
    .NARROW_R (NARROW_R),
    .WIDE_R   (WIDE_R)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgData (cfgData),
    .inA     (inA),
    .inQ     (inQ),
    .outData (outData)
  );

endmodule

// File: tb/montReduce_test.sv
`timescale 1ns/1ps
module montReduce_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgData = '0;
  logic        inValid = 1'b0;
  logic [1:0]  inOp = '0;
  logic [63:0] inA = '0;
  logic [63:0] inQ = '0;
  logic        outValid;
  logic [63:0] outData;

  int total = 0;
  int bad = 0;

  localparam logic [63:0] Q_N = 64'd3329;
  localparam logic [63:0] Q_W = 64'd8380417;
  localparam logic [15:0] INV_N = 16'hF301;       // 3329^-1 mod 2^16
  localparam logic [31:0] INV_W = 32'h0380_2001;  // 8380417^-1 mod 2^32

  always #2.5 clk = ~clk;

  montReduce uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .inValid(inValid), .inOp(inOp), .inA(inA), .inQ(inQ),
    .outValid(outValid), .outData(outData)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] a;
    logic [63:0] q;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 64'h0000_0000_0001_0000, 64'd3329, 64'd1},                      // R1
    '{2'd0, 64'd3329,                64'd3329, 64'd0},                      // R1
    '{2'd0, 64'd1,                   64'd3329, 64'd169},                    // R1
    '{2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3329, 64'hFFFF_FFFF_FFFF_FF57},    // R1 -1 -> -169
    '{2'd0, 64'h0000_0000_0007_0D01, 64'd3329, 64'd7},                      // R1
    '{2'd0, 64'hFFFF_FFFF_FFFF_0000, 64'd3329, 64'hFFFF_FFFF_FFFF_FFFF},    // R1
    '{2'd1, 64'h0000_0000_0001_0000, 64'd3329, 64'd1},                      // R2
    '{2'd1, 64'd3329,                64'd3329, 64'd0},                      // R2
    '{2'd1, 64'd1,                   64'd3329, 64'd3160},                   // R2
    '{2'd2, 64'h0000_0001_0000_0000, 64'd8380417, 64'd1},                   // R3
    '{2'd2, 64'd8380417,             64'd8380417, 64'd0},                   // R3
    '{2'd2, 64'd1,                   64'd8380417, 64'hFFFF_FFFF_FFFE_4060}, // R3 -> -114592
    '{2'd2, 64'h0000_0005_007F_E001, 64'd8380417, 64'd5},                   // R3
    '{2'd3, 64'h0000_0000_0001_2345, 64'd3329, 64'd0}                       // R4
  };

  function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a,
                                        input logic [63:0] q);
    logic [15:0] t16;
    logic [31:0] t32;
    logic signed [63:0] t;
    logic [63:0] s;
    t16 = 16'(a[15:0] * INV_N);
    t32 = 32'(a[31:0] * INV_W);
    case (op)
      2'd0: begin t = {{48{t16[15]}}, t16}; s = a - 64'(t * q); return $unsigned($signed(s) >>> 16); end
      2'd1: begin s = a + 64'({48'd0, t16} * q); return s >> 16; end
      2'd2: begin t = {{32{t32[31]}}, t32}; s = a - 64'(t * q); return $unsigned($signed(s) >>> 32); end
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive after a falling edge, read at the next falling edge
  task automatic issue(input logic [1:0] op, input logic [63:0] a, input logic [63:0] q);
    inValid = 1'b1; inOp = op; inA = a; inQ = q;
    @(negedge clk);
  endtask

  task automatic loadConst(input logic sel, input logic [31:0] d);
    inValid = 1'b0; cfgWrEn = 1'b1; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] seed;
    logic [63:0] held;
    inValid = 1'b1; inOp = 2'd0; inA = 64'd5;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 outData after reset", outData, 64'd0);
    check("R8 outValid after reset", {63'd0, outValid}, 64'd0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // R8: constants are zero after reset, so t is zero
    issue(2'd0, 64'h0000_0000_0003_0001, Q_N);
    check("R8 narrow constant zero", outData, 64'd3);
    issue(2'd2, 64'h0000_0002_0000_0005, Q_W);
    check("R8 wide constant zero", outData, 64'd2);

    // R7: upper cfgData bits ignored for the narrow constant
    loadConst(1'b0, {16'hABCD, INV_N});
    loadConst(1'b1, INV_W);

    // table walk: R1 R2 R3 R4 and R5
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].a, VECS[i].q);
      check($sformatf("R1/R2/R3/R4 vector %0d", i), outData, VECS[i].exp);
      check("R5 outValid one cycle after issue", {63'd0, outValid}, 64'd1);
    end

    // model sweep over all ops with both moduli; R9 sign/zero extension
    seed = 64'h1234_5678_9ABC_DEF1;
    for (int i = 0; i < 24; i++) begin
      logic [1:0] op;
      logic [63:0] q;
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      op = 2'(i % 3);
      q = (op == 2'd2) ? Q_W : Q_N;
      issue(op, {{32{seed[63]}}, seed[63:32]}, q);
      check($sformatf("R1/R2/R3 model op %0d", op), outData, model(op, {{32{seed[63]}}, seed[63:32]}, q));
      if (op == 2'd1)
        check("R9 add form top bits zero", {48'd0, outData[63:48]}, 64'd0);
      else if (op == 2'd0)
        check("R9 narrow sign extension", {63'd0, (&outData[63:47]) | ~(|outData[63:47])}, 64'd1);
      else
        check("R9 wide sign extension", {63'd0, (&outData[63:31]) | ~(|outData[63:31])}, 64'd1);
    end

    // R6: idle cycles keep the result; R5 valid drops
    issue(2'd0, 64'd1, Q_N);
    held = outData;
    inValid = 1'b0; inOp = 2'd2; inA = 64'hDEAD_BEEF_0000_1111; inQ = Q_W;
    @(negedge clk);
    check("R6 hold with inValid low", outData, held);
    check("R5 outValid low when idle", {63'd0, outValid}, 64'd0);
    inOp = 2'd3;
    @(negedge clk);
    check("R6 hold across second idle cycle", outData, 64'd169);

    // R7: write in the same cycle as an issue uses the old constant
    cfgWrEn = 1'b1; cfgSel = 1'b0; cfgData = 32'd0;
    issue(2'd0, 64'd1, Q_N);
    cfgWrEn = 1'b0;
    check("R7 same-cycle write uses old narrow", outData, 64'd169);
    issue(2'd0, 64'd1, Q_N);
    check("R7 new narrow constant applied", outData, 64'd0);
    // R7: narrow write leaves the wide constant untouched
    issue(2'd2, 64'h0000_0001_0000_0000, Q_W);
    check("R7 wide constant kept", outData, 64'd1);
    cfgWrEn = 1'b1; cfgSel = 1'b1; cfgData = 32'd0;
    issue(2'd2, 64'd1, Q_W);
    cfgWrEn = 1'b0;
    check("R7 same-cycle write uses old wide", outData, 64'hFFFF_FFFF_FFFE_4060);
    issue(2'd2, 64'h0000_0003_0000_0001, Q_W);
    check("R7 new wide constant applied", outData, 64'd3);

    inValid = 1'b0;
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule